// File: doc/BRIEF.md
# Peripheral Interrupt Request Merger

This block folds several request sources of one peripheral into a single maskable interrupt request. Each source has a status flag and an enable flag. Hardware events set the status flag, and software clears it. The request output is not a latch. It is computed live from the status and enable flags, so it rises when an enabled source is flagged and falls as soon as no enabled source remains flagged. This is true whether or not the interrupt was ever taken.

A small register port gives software three things. It can read and clear the status flags. It can read and write the enable flags. It can read and write a control register, which holds a 3-bit priority level and shows a read-only copy of the request. The block combines the request, the global interrupt flag and the processor's current priority level into an accept output. Software finds the source of an interrupt by reading the status flags. The acknowledge input leaves all state untouched.

Top module: `irq_merge`

## Requirements
- R1: A 1 on `src_evt[i]` at a clock edge sets status bit i. The bit then stays 1 until software clears it.
- R2: `irq_req` is 1 whenever some bit i has status i = 1 and enable i = 1. It follows register writes in the cycle after the write edge, with no further delay.
- R3: `irq_req` is 0 whenever no bit has both status and enable set. It falls without any acknowledge.
- R4: The control register is at address 2. Bits [2:0] hold the level, and bit 3 reads as the current `irq_req`. Writes to bit 3 have no effect on the request.
- R5: Pulses on `ack` change no status bit and do not lower `irq_req`.
- R6: A write to address 0 clears each status bit whose data bit is 0. Data bits that are 1 leave the matching status bits unchanged. Address 1 holds the enable bits.
- R7: When an event and a clearing write hit the same status bit in the same cycle, the bit ends at 1.
- R8: `irq_take` is 1 exactly when `gie` is 1, `irq_req` is 1, and the level is strictly greater than `cpu_ipl`.
- R9: A level of 0 never produces `irq_take`.
- R10: While `irq_req` is 1 and several sources are enabled, a further source setting its status keeps `irq_req` at 1 in every cycle.
- R11: After reset, the status, enable and level are all 0, and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 status, 1 enable, 2 control) |
| wr_data | input | 4 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 4 | Read data, combinational from `rd_addr` |
| src_evt | input | 4 | Per-source set events |
| ack | input | 1 | Interrupt acknowledge from the CPU |
| gie | input | 1 | Global interrupt enable flag |
| cpu_ipl | input | 3 | Current processor priority level |
| irq_req | output | 1 | Merged request |
| irq_take | output | 1 | Request accepted for the CPU |

## Verification
A hardware set and a software clear can land on the same status bit in the same clock cycle. To provoke this, the bench drives a clearing write of all zeros to address 0 and, in the same cycle, an event on source 0. It then reads the status register back and expects bit 0 to be 1 and every other bit to be 0. A second overlap pairs acknowledge pulses with a live request, and the bench judges that case by reading back the status register and the request.

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NSRC = 4,
  parameter int LVLW = 3,
  parameter int DW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [NSRC-1:0] src_evt,
  input  logic            ack,
  input  logic            gie,
  input  logic [LVLW-1:0] cpu_ipl,
  output logic            irq_req,
  output logic            irq_take
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  logic [NSRC-1:0] stat_q, en_q, keep;
  logic [LVLW-1:0] lvl_q;
  logic            stat_wr;

  assign stat_wr = wr_en && (wr_addr == A_STAT);
  assign keep    = stat_wr ? wr_data[NSRC-1:0] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
    end else begin
      stat_q <= (stat_q & keep) | src_evt;
      if (wr_en && wr_addr == A_EN)   en_q  <= wr_data[NSRC-1:0];
      if (wr_en && wr_addr == A_CTRL) lvl_q <= wr_data[LVLW-1:0];
    end
  end

  assign irq_req  = |(stat_q & en_q);
  assign irq_take = gie && irq_req && (lvl_q > cpu_ipl);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STAT:  rd_data[NSRC-1:0] = stat_q;
      A_EN:    rd_data[NSRC-1:0] = en_q;
      A_CTRL:  rd_data[LVLW:0]   = {irq_req, lvl_q};
      default: rd_data = '0;
    endcase
  end

  AST_SET_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(src_evt)) == '0)); // R1
  AST_ACK_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !stat_wr) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5
  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat_q & $past(stat_q & wr_data[NSRC-1:0])) == $past(stat_q & wr_data[NSRC-1:0]))); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((stat_q & $past(src_evt)) == $past(src_evt))); // R7
  AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_req && gie)); // R8
  AST_LVL0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_CTRL && rd_data[LVLW-1:0] == '0) |-> !irq_take); // R9
endmodule

// File: tb/irq_merge_test.sv
module irq_merge_test;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, ack = 0, gie = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [3:0] wr_data = 0, src_evt = 0, rd_data;
  logic [2:0] cpu_ipl = 0;
  logic       irq_req, irq_take;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_merge uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .src_evt(src_evt),
    .ack(ack), .gie(gie), .cpu_ipl(cpu_ipl), .irq_req(irq_req), .irq_take(irq_take));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic evt(input logic [3:0] m);
    @(negedge clk); src_evt = m;
    @(negedge clk); src_evt = 0;
  endtask

  task automatic t_reset;
    logic [3:0] d;
    rd(0, d); chk("R11 status", d, 0);
    rd(1, d); chk("R11 enable", d, 0);
    rd(2, d); chk("R11 control", d, 0);
    chk("R11 irq_req", irq_req, 0);
    chk("R11 irq_take", irq_take, 0);
  endtask

  task automatic t_mask;
    logic [3:0] d;
    evt(4'b0100);
    rd(0, d); chk("R1 status set", d, 4'b0100);
    chk("R3 masked req", irq_req, 0);
    repeat (3) @(negedge clk);
    rd(0, d); chk("R1 status held", d, 4'b0100);
    wr(1, 4'b0100); chk("R2 req after enable", irq_req, 1);
    wr(1, 4'b0011); chk("R3 req after disable", irq_req, 0);
    wr(1, 4'b0100); chk("R2 req re-enabled", irq_req, 1);
  endtask

  task automatic t_ack;
    logic [3:0] d;
    repeat (3) begin
      @(negedge clk); ack = 1;
      @(negedge clk); ack = 0;
    end
    rd(0, d); chk("R5 status after ack", d, 4'b0100);
    chk("R5 req after ack", irq_req, 1);
  endtask

  task automatic t_ir_write;
    logic [3:0] d;
    wr(2, 4'b0000);
    chk("R4 req after writing 0", irq_req, 1);
    rd(2, d); chk("R4 IR read bit", d[3], 1);
  endtask

  task automatic t_no_gap;
    logic [3:0] d;
    int drops = 0;
    wr(1, 4'b0110);
    @(negedge clk); src_evt = 4'b0010;
    for (int i = 0; i < 4; i++) begin
      if (!irq_req) drops++;
      @(negedge clk); src_evt = 0;
    end
    chk("R10 req gaps", drops, 0);
    rd(0, d); chk("R10 status both", d, 4'b0110);
  endtask

  task automatic t_clear;
    logic [3:0] d;
    wr(0, 4'b1011);
    rd(0, d); chk("R6 clear bit2 only", d, 4'b0010);
    chk("R2 req from bit1", irq_req, 1);
    wr(0, 4'b1101);
    rd(0, d); chk("R6 clear bit1", d, 4'b0000);
    chk("R3 req drops", irq_req, 0);
    wr(2, 4'b1000);
    chk("R4 write IR 1 ignored", irq_req, 0);
    rd(2, d); chk("R4 control read", d, 4'b0000);
  endtask

  task automatic t_race;
    logic [3:0] d;
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 4'b0000; src_evt = 4'b0001;
    @(negedge clk); wr_en = 0; src_evt = 0;
    rd(0, d); chk("R7 set wins", d, 4'b0001);
  endtask

  task automatic t_accept;
    wr(1, 4'b0001);
    chk("R2 req src0", irq_req, 1);
    wr(2, 4'd3); gie = 1; cpu_ipl = 2; #1;
    chk("R8 level above ipl", irq_take, 1);
    cpu_ipl = 3; #1; chk("R8 level equal ipl", irq_take, 0);
    cpu_ipl = 4; #1; chk("R8 level below ipl", irq_take, 0);
    cpu_ipl = 0; gie = 0; #1; chk("R8 gie low", irq_take, 0);
    gie = 1; #1; chk("R8 gie high", irq_take, 1);
    wr(2, 4'd0); chk("R9 level zero", irq_take, 0);
    wr(2, 4'd7); cpu_ipl = 6; #1; chk("R8 level 7 ipl 6", irq_take, 1);
    wr(0, 4'b0000);
    chk("R8 no req no take", irq_take, 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_ack();
    t_ir_write();
    t_no_gap();
    t_clear();
    t_race();
    t_accept();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule